// File: doc/BRIEF.md
# Alarm and Countdown Timer Interrupt Unit

This unit raises one active-low, open-drain interrupt request from two sources. The first is a calendar alarm: up to four programmed fields (minute, hour, day of month, weekday) are compared with the current calendar values supplied by the timekeeping logic. The second is an 8-bit countdown timer that runs from one of four selectable source rates. The unit also drives a square-wave clock output at one of four rates, with an output enable for an open-drain pad.

All rates come from one internal divider chain. The chain advances on `osc_tick`, which fires at twice the output base rate, i.e. 65536 times per nominal second when `BASE_LOG2` = 16. Software reaches the unit through a simple register port. Writes take effect on the next clock edge. Reads are combinational from `rd_addr`. Register addresses: 0 interrupt control/status, 1 minute alarm, 2 hour alarm, 3 day alarm, 4 weekday alarm, 5 clock-output control, 6 timer control, 7 timer count.

Top module: `alarm_timer_irq`

## Requirements
- R1: After reset, reads at addresses 0..7 return 0x00, 0x80, 0x80, 0x80, 0x80, 0x80, 0x03, 0x00, `irq_low` is 0 and `clko_en` is 0.
- R1: Unimplemented bits read as 0.
  - Alarm registers keep bit 7 and a value field of 7 bits (minute), 6 bits (hour, day) or 3 bits (weekday).
  - The control register keeps bit 4 pulse mode, bit 3 alarm flag, bit 2 timer flag, bit 1 alarm interrupt enable and bit 0 timer interrupt enable.
- R2: An alarm field takes part in the compare only when its bit 7 is 0. With every field's bit 7 at 1, the alarm flag never sets.
- R3: The alarm flag sets in the cycle after all enabled fields start to equal the current values. Once cleared, it stays clear while the match persists, and sets again only on a new match.
- R4: Writing address 0 with 0 in bit 3 (alarm flag) or bit 2 (timer flag) clears that flag. Writing 1 in that bit leaves the flag unchanged. Otherwise a flag holds until cleared.
- R5: Timer control bits 1:0 select the source.
  - 00 ticks every 16 osc ticks.
  - 01 ticks every 1024 osc ticks.
  - 10 ticks every 2^BASE_LOG2 osc ticks.
  - 11 ticks every SEC_PER_MIN·2^BASE_LOG2 osc ticks.
  - Timer control bit 7 enables counting.
- R6: Writing address 7 loads both the live count and the reload value.
  - Each source tick decrements the count.
  - Where the count would reach zero, the timer flag sets and the count reloads.
  - Reads of address 7 return the live count.
  - A loaded value of 0 keeps the timer stopped.
  - With bit 7 at 0 the count holds.
- R7: `irq_low` = (alarm flag AND alarm enable) OR (timer term). In level mode (control bit 4 = 0) the timer term is timer flag AND timer enable.
- R8: In pulse mode the timer term is a pulse gated by the timer enable. The pulse starts at each expiry and lasts 8 osc ticks (source 00), 512 (source 01) or 1024 (sources 10 and 11). An active alarm flag with its enable still holds `irq_low` at 1.
- R9: Clock-output control bits 1:0 select a half period.
  - 00 gives a half period of 1 osc tick.
  - 01 gives 32 osc ticks.
  - 10 gives 1024 osc ticks.
  - 11 gives 2^(BASE_LOG2-1) osc ticks.
  - Bit 7 at 0 sets `clko_en`. Bit 7 at 1 clears it (pad released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Divider chain advance enable |
| cur_min | input | 7 | Current minute (BCD) |
| cur_hour | input | 6 | Current hour (BCD) |
| cur_day | input | 6 | Current day of month (BCD) |
| cur_wday | input | 3 | Current weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| irq_low | output | 1 | 1 = drive interrupt pad low |
| clko_level | output | 1 | Square-wave level |
| clko_en | output | 1 | Square-wave pad enable |

## Verification
The bench builds the unit with BASE_LOG2 = 12 and SEC_PER_MIN = 3 and holds `osc_tick` at 1. This brings the one-second source (4096 cycles) and the one-minute source (12288 cycles) within a short run. The bench can then measure the exact pulse width and repeat period for all four timer sources, and the exact half period of all four clock-output taps. The fast sources keep their default ratios, so their 16-, 512- and 8-cycle figures are exercised as built.

// File: rtl/atirq_pkg.sv
// Shared register addresses, source codes and divider tick bundle for the
// alarm/timer interrupt unit. Assumes a 3-bit register address space.
package atirq_pkg;

    typedef enum logic [2:0] {
        A_CTRL     = 3'd0,
        A_ALM_MIN  = 3'd1,
        A_ALM_HOUR = 3'd2,
        A_ALM_DAY  = 3'd3,
        A_ALM_WDAY = 3'd4,
        A_CLKO     = 3'd5,
        A_TCTRL    = 3'd6,
        A_TCOUNT   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_MID  = 2'd1,
        SRC_SEC  = 2'd2,
        SRC_MIN  = 2'd3
    } tsrc_e;

    // One-cycle enables from the divider chain; slower ones are nested in faster ones.
    typedef struct packed {
        logic t8192;
        logic t4096;
        logic t128;
        logic t64;
        logic t1;
        logic tmin;
    } tick_s;

    localparam int NUM_ALM = 4;

endpackage

// File: rtl/atirq_prescaler.sv
// Divider chain: a binary counter advanced by osc_tick, yielding nested
// one-cycle tick enables and four square-wave taps. Assumes BASE_LOG2 >= 12
// and SEC_PER_MIN >= 2; osc_tick runs at twice the fastest output rate.
module atirq_prescaler
    import atirq_pkg::*;
#(
    parameter int BASE_LOG2   = 16,
    parameter int SEC_PER_MIN = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    output tick_s       ticks,
    output logic [3:0]  sq_taps
);
    localparam int SEC_W  = $clog2(SEC_PER_MIN);
    localparam int K8192  = 3;
    localparam int K4096  = 4;
    localparam int K128   = 9;
    localparam int K64    = 10;
    localparam int NTAP   = 4;
    localparam int TAP_IDX [NTAP] = '{0, 5, 10, BASE_LOG2 - 1};

    logic [BASE_LOG2-1:0] div_q;
    logic [SEC_W-1:0]     sec_q;

    // Advance the divider chain on every oscillator enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (osc_tick) div_q <= div_q + 1'b1;
    end

    assign ticks.t8192 = osc_tick & (&div_q[K8192-1:0]);
    assign ticks.t4096 = osc_tick & (&div_q[K4096-1:0]);
    assign ticks.t128  = osc_tick & (&div_q[K128-1:0]);
    assign ticks.t64   = osc_tick & (&div_q[K64-1:0]);
    assign ticks.t1    = osc_tick & (&div_q);
    assign ticks.tmin  = ticks.t1 & (sec_q == SEC_W'(SEC_PER_MIN - 1));

    // Count whole seconds to form the one-minute tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          sec_q <= '0;
        else if (ticks.tmin) sec_q <= '0;
        else if (ticks.t1)   sec_q <= sec_q + 1'b1;
    end

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            assign sq_taps[g] = div_q[TAP_IDX[g]];
        end
    endgenerate

    p_minute_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ticks.tmin |=> (sec_q == '0));

    p_second_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ticks.t1 && !ticks.tmin) |=> (sec_q == $past(sec_q) + 1'b1));

endmodule

// File: rtl/atirq_alarm.sv
// Calendar alarm: four field registers, each with an active-low compare
// enable in bit 7, compared against the live calendar. Emits a one-cycle
// strobe when the combined match begins. Assumes BCD inputs from outside.
module atirq_alarm
    import atirq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic [6:0]                cur_min,
    input  logic [5:0]                cur_hour,
    input  logic [5:0]                cur_day,
    input  logic [2:0]                cur_wday,
    output logic [NUM_ALM-1:0][7:0]   alm_rd,
    output logic                      hit_rise
);
    localparam logic [6:0] FMASK [NUM_ALM] = '{7'h7F, 7'h3F, 7'h3F, 7'h07};

    logic [NUM_ALM-1:0] off_q;
    logic [NUM_ALM-1:0] field_ok;
    logic [6:0]         val_q [NUM_ALM];
    logic [6:0]         cur_v [NUM_ALM];
    logic               match;
    logic               match_q;

    assign cur_v[0] = cur_min;
    assign cur_v[1] = {1'b0, cur_hour};
    assign cur_v[2] = {1'b0, cur_day};
    assign cur_v[3] = {4'b0, cur_wday};

    generate
        for (genvar i = 0; i < NUM_ALM; i++) begin : g_field
            localparam logic [2:0] MY_ADDR = 3'(int'(A_ALM_MIN) + i);
            // Capture the field's disable bit and masked value on a write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    off_q[i] <= 1'b1;
                    val_q[i] <= '0;
                end else if (wr_en && wr_addr == MY_ADDR) begin
                    off_q[i] <= wr_data[7];
                    val_q[i] <= wr_data[6:0] & FMASK[i];
                end
            end
            assign field_ok[i] = off_q[i] | (val_q[i] == (cur_v[i] & FMASK[i]));
            assign alm_rd[i]   = {off_q[i], val_q[i]};
        end
    endgenerate

    assign match = (|(~off_q)) & (&field_ok);

    // Remember the previous match so only its start is reported.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign hit_rise = match & ~match_q;

    p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_rise |=> !hit_rise);

    p_all_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&off_q) |-> !hit_rise);

endmodule

// File: rtl/atirq_timer.sv
// Countdown timer with reload: loads an 8-bit value, decrements on the
// selected source tick while enabled, reloads and strobes expire at the end,
// and stretches each expiry into a pulse one pulse-clock period long.
module atirq_timer
    import atirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tick_s       ticks,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  tctrl_rd,
    output logic [7:0]  count_rd,
    output logic        expire,
    output logic        pulse_q
);
    logic        te_q;
    tsrc_e       src_q;
    logic [7:0]  reload_q;
    logic [7:0]  live_q;
    logic        src_tick;
    logic        pulse_tick;
    logic        load;
    logic        step;

    // Pick the countdown source and the matching pulse-length clock.
    always_comb begin
        unique case (src_q)
            SRC_FAST: begin src_tick = ticks.t4096; pulse_tick = ticks.t8192; end
            SRC_MID:  begin src_tick = ticks.t64;   pulse_tick = ticks.t128;  end
            SRC_SEC:  begin src_tick = ticks.t1;    pulse_tick = ticks.t64;   end
            default:  begin src_tick = ticks.tmin;  pulse_tick = ticks.t64;   end
        endcase
    end

    assign load   = wr_en && (wr_addr == A_TCOUNT);
    assign step   = te_q && src_tick && (reload_q != 8'd0) && !load;
    assign expire = step && (live_q <= 8'd1);

    // Hold timer enable and source selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q  <= 1'b0;
            src_q <= SRC_MIN;
        end else if (wr_en && wr_addr == A_TCTRL) begin
            te_q  <= wr_data[7];
            src_q <= tsrc_e'(wr_data[1:0]);
        end
    end

    // Load, decrement and reload the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            live_q   <= '0;
        end else if (load) begin
            reload_q <= wr_data;
            live_q   <= wr_data;
        end else if (expire) begin
            live_q   <= reload_q;
        end else if (step) begin
            live_q   <= live_q - 1'b1;
        end
    end

    // Stretch each expiry until the next pulse-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          pulse_q <= 1'b0;
        else if (expire)     pulse_q <= 1'b1;
        else if (pulse_tick) pulse_q <= 1'b0;
    end

    assign tctrl_rd = {te_q, 5'b0, src_q};
    assign count_rd = live_q;

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (live_q == $past(reload_q)));

    p_stopped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == 8'd0 && !load) |=> $stable(live_q));

    p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!te_q && !load) |=> $stable(live_q));

    p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pulse_q);

endmodule

// File: rtl/alarm_timer_irq.sv
// Top of the alarm/timer interrupt unit: control and flag register, clock
// output control, read multiplexer and interrupt combination. Flags obey
// write-zero-clears / write-one-keeps; a set event in the same cycle wins.
module alarm_timer_irq
    import atirq_pkg::*;
#(
    parameter int BASE_LOG2   = 16,
    parameter int SEC_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic [6:0] cur_min,
    input  logic [5:0] cur_hour,
    input  logic [5:0] cur_day,
    input  logic [2:0] cur_wday,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq_low,
    output logic       clko_level,
    output logic       clko_en
);
    tick_s                    ticks;
    logic [3:0]               sq_taps;
    logic [NUM_ALM-1:0][7:0]  alm_rd;
    logic                     alarm_rise;
    logic [7:0]               tctrl_rd;
    logic [7:0]               count_rd;
    logic                     expire;
    logic                     pulse_q;
    logic                     ctrl_wr;
    logic                     pmode_q, af_q, tf_q, aie_q, tie_q;
    logic                     fe_q;
    logic [1:0]               fd_q;
    logic                     timer_term;

    atirq_prescaler #(.BASE_LOG2(BASE_LOG2), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .ticks(ticks), .sq_taps(sq_taps)
    );

    atirq_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_wday(cur_wday), .alm_rd(alm_rd),
        .hit_rise(alarm_rise)
    );

    atirq_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .ticks(ticks), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tctrl_rd(tctrl_rd),
        .count_rd(count_rd), .expire(expire), .pulse_q(pulse_q)
    );

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    // Control bits and sticky flags; writing 0 clears a flag, 1 keeps it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmode_q <= 1'b0;
            aie_q   <= 1'b0;
            tie_q   <= 1'b0;
            af_q    <= 1'b0;
            tf_q    <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                pmode_q <= wr_data[4];
                aie_q   <= wr_data[1];
                tie_q   <= wr_data[0];
            end
            af_q <= (ctrl_wr ? (af_q & wr_data[3]) : af_q) | alarm_rise;
            tf_q <= (ctrl_wr ? (tf_q & wr_data[2]) : tf_q) | expire;
        end
    end

    // Clock output enable (active low bit) and rate selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q <= 1'b1;
            fd_q <= 2'b00;
        end else if (wr_en && wr_addr == A_CLKO) begin
            fe_q <= wr_data[7];
            fd_q <= wr_data[1:0];
        end
    end

    assign clko_level = sq_taps[fd_q];
    assign clko_en    = ~fe_q;

    assign timer_term = tie_q & (pmode_q ? pulse_q : tf_q);
    assign irq_low    = (af_q & aie_q) | timer_term;

    // Combinational register read-back.
    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            A_CTRL:     rd_data = {3'b0, pmode_q, af_q, tf_q, aie_q, tie_q};
            A_ALM_MIN:  rd_data = alm_rd[0];
            A_ALM_HOUR: rd_data = alm_rd[1];
            A_ALM_DAY:  rd_data = alm_rd[2];
            A_ALM_WDAY: rd_data = alm_rd[3];
            A_CLKO:     rd_data = {fe_q, 5'b0, fd_q};
            A_TCTRL:    rd_data = tctrl_rd;
            default:    rd_data = count_rd;
        endcase
    end

    p_af_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_q) |-> $past(alarm_rise));

    p_af_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[3] && !alarm_rise) |=> !af_q);

    p_tf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[2] && !expire) |=> !tf_q);

    p_tf_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_q && !(ctrl_wr && !wr_data[2])) |=> tf_q);

    p_alarm_holds_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (af_q && aie_q) |-> irq_low);

    p_level_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pmode_q && tie_q && tf_q) |-> irq_low);

endmodule

// File: tb/alarm_timer_irq_test.sv
module alarm_timer_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_day = '0;
    logic [2:0] cur_wday = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_low;
    logic       clko_level;
    logic       clko_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    alarm_timer_irq #(.BASE_LOG2(12), .SEC_PER_MIN(3)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .cur_wday(cur_wday), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_low(irq_low), .clko_level(clko_level), .clko_en(clko_en)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_irq(output int hi, output int per);
        hi = 0; per = 0;
        @(negedge clk);
        while (irq_low) @(negedge clk);
        while (!irq_low) @(negedge clk);
        while (irq_low) begin hi++; @(negedge clk); end
        per = hi;
        while (!irq_low) begin per++; @(negedge clk); end
    endtask

    task automatic measure_toggle(output int half);
        logic v;
        @(negedge clk);
        v = clko_level;
        while (clko_level == v) @(negedge clk);
        v = clko_level;
        half = 0;
        while (clko_level == v) begin half++; @(negedge clk); end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [7:0] exp [8] = '{8'h00, 8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 8'h03, 8'h00};
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reset read addr %0d", a), d, exp[a]);
        end
        check("R1 reset irq_low", irq_low, 0);
        check("R1 reset clko_en", clko_en, 0);
    endtask

    task automatic t_regmap;
        logic [7:0] d;
        wr(3'd1, 8'hFF); rd(3'd1, d); check("R1 minute alarm width", d, 8'hFF);
        wr(3'd2, 8'hFF); rd(3'd2, d); check("R1 hour alarm width", d, 8'hBF);
        wr(3'd3, 8'hFF); rd(3'd3, d); check("R1 day alarm width", d, 8'hBF);
        wr(3'd4, 8'hFF); rd(3'd4, d); check("R1 weekday alarm width", d, 8'h87);
        wr(3'd0, 8'hFF); rd(3'd0, d); check("R1 control bits", d, 8'h13);
        wr(3'd0, 8'h00);
        for (int a = 1; a < 5; a++) wr(3'(a), 8'h80);
    endtask

    task automatic t_alarm;
        logic [7:0] d;
        cur_min = 7'h15; cur_hour = 6'h08; cur_day = 6'h03; cur_wday = 3'd2;
        idle(3);
        rd(3'd0, d); check("R2 all fields disabled no flag", d[3], 0);
        wr(3'd1, 8'h15); idle(2);
        rd(3'd0, d); check("R3 minute match sets flag", d[3], 1);
        wr(3'd0, 8'h00); idle(5);
        rd(3'd0, d); check("R3 stays clear during same match", d[3], 0);
        cur_min = 7'h16; idle(3); cur_min = 7'h15; idle(2);
        rd(3'd0, d); check("R3 new match sets again", d[3], 1);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h09);
        cur_min = 7'h16; idle(3); cur_min = 7'h15; idle(3);
        rd(3'd0, d); check("R2 enabled hour mismatch blocks", d[3], 0);
        wr(3'd2, 8'h08); idle(2);
        rd(3'd0, d); check("R2 hour and minute both match", d[3], 1);
        wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd0, 8'h00);
        wr(3'd4, 8'h03); idle(3);
        rd(3'd0, d); check("R2 weekday mismatch", d[3], 0);
        cur_wday = 3'd3; idle(2);
        rd(3'd0, d); check("R2 weekday match", d[3], 1);
        wr(3'd0, 8'h08); idle(2);
        rd(3'd0, d); check("R4 write one keeps alarm flag", d[3], 1);
        wr(3'd0, 8'h00); idle(1);
        rd(3'd0, d); check("R4 write zero clears alarm flag", d[3], 0);
    endtask

    task automatic t_timer_flag;
        logic [7:0] d;
        wr(3'd6, 8'h80); wr(3'd7, 8'd1); idle(40);
        rd(3'd0, d); check("R6 timer flag after expiry", d[2], 1);
        wr(3'd0, 8'h04); idle(1);
        rd(3'd0, d); check("R4 write one keeps timer flag", d[2], 1);
        wr(3'd0, 8'h00); idle(1);
        rd(3'd0, d); check("R4 write zero clears timer flag", d[2], 0);
        idle(40);
        rd(3'd0, d); check("R6 reload repeats expiry", d[2], 1);
        wr(3'd0, 8'h01); idle(1);
        check("R7 level timer term drives irq", irq_low, 1);
        wr(3'd0, 8'h00); idle(1);
        check("R7 timer enable off releases irq", irq_low, 0);
        wr(3'd7, 8'd0); idle(200);
        rd(3'd0, d); check("R6 zero load keeps timer stopped flag", d[2], 0);
        rd(3'd7, d); check("R6 zero load count stays", d, 0);
        wr(3'd6, 8'h00); wr(3'd7, 8'd5); idle(3000);
        rd(3'd7, d); check("R6 disabled count holds", d, 5);
        wr(3'd6, 8'h80); wr(3'd7, 8'd200);
        begin
            logic [7:0] a, b;
            rd(3'd7, a);
            idle(159);
            rd(3'd7, b);
            check("R6 live count 10 ticks in 160 cycles", int'(a) - int'(b), 10);
        end
        wr(3'd6, 8'h00); wr(3'd0, 8'h00);
    endtask

    task automatic t_irq_alarm;
        cur_wday = 3'd4; idle(2);
        cur_wday = 3'd3; idle(2);
        check("R7 alarm flag without enable", irq_low, 0);
        wr(3'd0, 8'h0A); idle(1);
        check("R7 alarm flag with enable", irq_low, 1);
        wr(3'd0, 8'h02); idle(1);
        check("R7 alarm cleared releases irq", irq_low, 0);
    endtask

    task automatic t_pulse;
        int hi, per;
        int src_per [4] = '{16, 1024, 4096, 12288};
        int src_w   [4] = '{8, 512, 1024, 1024};
        int nload   [4] = '{3, 2, 1, 1};
        wr(3'd0, 8'h11);
        for (int s = 0; s < 4; s++) begin
            wr(3'd6, 8'(8'h80 | s));
            wr(3'd7, 8'(nload[s]));
            measure_irq(hi, per);
            check($sformatf("R8 pulse width src %0d", s), hi, src_w[s]);
            check($sformatf("R5 expiry period src %0d", s), per, src_per[s] * nload[s]);
        end
        wr(3'd6, 8'h80); wr(3'd7, 8'd3);
        cur_wday = 3'd4; idle(2); cur_wday = 3'd3; idle(2);
        wr(3'd0, 8'h1B);
        begin
            int lows = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!irq_low) lows++;
            end
            check("R8 alarm holds irq in pulse mode", lows, 0);
        end
        wr(3'd6, 8'h00); wr(3'd0, 8'h00); wr(3'd4, 8'h80);
    endtask

    task automatic t_clko;
        int h;
        int exp_h [4] = '{1, 32, 1024, 2048};
        for (int s = 0; s < 4; s++) begin
            wr(3'd5, 8'(s));
            check($sformatf("R9 output enabled sel %0d", s), clko_en, 1);
            measure_toggle(h);
            check($sformatf("R9 half period sel %0d", s), h, exp_h[s]);
        end
        wr(3'd5, 8'h80); idle(1);
        check("R9 output disabled", clko_en, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        osc_tick = 1'b1;
        t_reset();
        t_regmap();
        t_alarm();
        t_timer_flag();
        t_irq_alarm();
        t_pulse();
        t_clko();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule